// File: doc/BRIEF.md
# Dual Potentiometer Two-Wire Command Front End

This block is the slave side of a two-wire serial bus for a chip that holds two digital potentiometers. It watches the clock and data lines, finds start and stop conditions, and checks the first byte of a frame against a fixed four-bit device code and a four-bit address taken from pins. It then reads an instruction byte that carries an opcode, a data-register select and a pot select, and it acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

The opcode decides how the frame goes on. A write gives one data byte. A read returns one byte, most significant bit first, taken from the register that the select outputs point at. A transfer has no data byte. A step command lets the master move the chosen wiper by one tap for each clock pulse, for as long as the frame lasts. The block does not hold the wiper or data registers. It presents the decoded selects and pulses a command strobe when a write or transfer frame ends with a stop. It pulses a separate step strobe for each step pulse. It also takes a busy flag from the register logic. While a nonvolatile write is running, the address byte is not acknowledged, so the master can poll until the write is done.

Top module: `pot_cmd_if`

## Requirements
- R1: After reset the open-drain enable, both strobes and all select outputs are 0. A start (SDA falling while SCL is high) begins a new frame from any state, including in the middle of a byte. A stop (SDA rising while SCL is high) returns the block to idle.
- R2: The first byte is acknowledged only when its bits [7:4] equal 0101 and its bits [3:0] equal `dev_addr_i`. The acknowledge is SDA held low through the ninth clock. On a mismatch nothing more in that frame is acknowledged.
- R3: While `nv_busy_i` is 1, a matching address byte is not acknowledged.
- R4: In the instruction byte, bits [7:4] are the opcode, [3:2] the data-register select, [1] must be 0 and [0] is the pot select. A valid instruction byte is acknowledged and appears on `sel_op_o`, `sel_dr_o` and `sel_pot_o` before its acknowledge clock.
- R5: An instruction byte whose opcode is outside the nine defined codes, or whose bit [1] is 1, is not acknowledged. The rest of the frame is ignored and no strobe is produced.
- R6: Opcodes 1010 (write wiper) and 1100 (write data register) take one data byte, which is acknowledged. `cmd_stb_o` pulses once, in the clock cycle after the stop that ends the frame, with the byte on `cmd_data_o`.
- R7: Opcodes 1101, 1110, 0001 and 1000 (single and global transfers) end after the acknowledged instruction byte. `cmd_stb_o` pulses once after the following stop, with the selects set from that instruction.
- R8: Opcodes 1001 (read wiper) and 1011 (read data register) return `rd_data_i`, sampled at the end of the instruction acknowledge, MSB first over eight clocks. The slave then releases SDA. A read produces no strobe.
- R9: After an acknowledged 0010 instruction, each later SCL high pulse ends with one `step_stb_o` pulse on its falling edge. `step_up_o` is 1 when SDA was high at the rising edge. A stop produces no step and no command strobe.
- R10: A repeated start, or a stop that arrives before a write frame has its data byte, drops the command and produces no strobe.
- R11: The open-drain enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_addr_i | input | 4 | Strapped device address |
| nv_busy_i | input | 1 | Nonvolatile write in progress |
| rd_data_i | input | 8 | Register value selected by the select outputs |
| sel_op_o | output | 4 | Last accepted opcode |
| sel_dr_o | output | 2 | Last accepted data-register select |
| sel_pot_o | output | 1 | Last accepted pot select |
| cmd_stb_o | output | 1 | One-cycle strobe committing a write or transfer |
| cmd_data_o | output | 8 | Data byte of the last write frame |
| step_stb_o | output | 1 | One-cycle strobe per step pulse |
| step_up_o | output | 1 | Direction of the current step, 1 toward the high end |

## Verification
A complete write or transfer is waiting for its stop to commit it. A new start that arrives in that window decides in a single cycle whether the pending command commits or is dropped. The bench provokes this by sending a full write frame and ending it with a repeated start instead of a stop. It then judges the result from the strobe count, which must not change until a later frame ends with a proper stop. Step and command strobes are also driven in neighbouring frames, and the bench checks that each kind is counted only for its own frame type.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER  = 4'b1010;
    localparam logic [3:0] OP_RD_DREG   = 4'b1011;
    localparam logic [3:0] OP_WR_DREG   = 4'b1100;
    localparam logic [3:0] OP_DREG2WIP  = 4'b1101;
    localparam logic [3:0] OP_WIP2DREG  = 4'b1110;
    localparam logic [3:0] OP_ALL_D2W   = 4'b0001;
    localparam logic [3:0] OP_ALL_W2D   = 4'b1000;
    localparam logic [3:0] OP_STEP      = 4'b0010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RMACK,
        ST_STEP,
        ST_HOLD
    } fsm_e;

    typedef enum logic [2:0] {
        K_BAD,
        K_RD,
        K_WR,
        K_XFR,
        K_STEP
    } kind_e;

endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pot_bus_cond.sv
module pot_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pot_opcode_dec.sv
module pot_opcode_dec
    import pot_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output kind_e             kind_o
);
    always_comb begin
        case (byte_i[7:4])
            OP_RD_WIPER, OP_RD_DREG:                        kind_o = K_RD;
            OP_WR_WIPER, OP_WR_DREG:                        kind_o = K_WR;
            OP_DREG2WIP, OP_WIP2DREG, OP_ALL_D2W, OP_ALL_W2D: kind_o = K_XFR;
            OP_STEP:                                        kind_o = K_STEP;
            default:                                        kind_o = K_BAD;
        endcase
        if (byte_i[1]) begin
            kind_o = K_BAD;
        end
    end
endmodule

// File: rtl/pot_cmd_if.sv
module pot_cmd_if
    import pot_cmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [3:0]        dev_addr_i,
    input  logic              nv_busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [3:0]        sel_op_o,
    output logic [1:0]        sel_dr_o,
    output logic              sel_pot_o,
    output logic              cmd_stb_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              step_stb_o,
    output logic              step_up_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    logic [1:0] raw_in;
    logic [1:0] syn_out;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    fsm_e               state;
    fsm_e               nstate;
    kind_e              rx_kind;
    kind_e              kind_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  sh_q;
    logic [BYTE_W-1:0]  rd_q;
    logic [BYTE_W-1:0]  rx_byte;
    logic [BYTE_W-1:0]  data_q;
    logic               nine_q;
    logic               pend_q;
    logic               pull_q;
    logic               stb_q;
    logic               step_q;
    logic               up_q;
    logic [3:0]         op_q;
    logic [1:0]         dr_q;
    logic               pot_q;
    logic               byte_done;
    logic               id_ok;
    logic               ack_end;
    logic               in_ack;

    assign raw_in = {scl_i, sda_i};

    pot_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_out)
    );

    assign scl_s = syn_out[1];
    assign sda_s = syn_out[0];

    pot_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};

    pot_opcode_dec u_dec (
        .byte_i (rx_byte),
        .kind_o (rx_kind)
    );

    assign byte_done = scl_rise && (cnt_q == LAST_BIT);
    assign id_ok     = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:0] == dev_addr_i) && !nv_busy_i;
    assign ack_end   = scl_fall && nine_q;
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_INSTR_ACK) || (state == ST_WDATA_ACK);

    // next-state logic
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = ST_ADDR;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (byte_done) nstate = id_ok ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (ack_end) nstate = ST_INSTR;
                ST_INSTR:     if (byte_done) nstate = (rx_kind != K_BAD) ? ST_INSTR_ACK : ST_IDLE;
                ST_INSTR_ACK: begin
                    if (ack_end) begin
                        case (kind_q)
                            K_RD:    nstate = ST_RDATA;
                            K_WR:    nstate = ST_WDATA;
                            K_STEP:  nstate = ST_STEP;
                            default: nstate = ST_HOLD;
                        endcase
                    end
                end
                ST_WDATA:     if (byte_done) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_end) nstate = ST_HOLD;
                ST_RDATA:     if (scl_fall && (cnt_q == ALL_BITS)) nstate = ST_RMACK;
                ST_RMACK:     if (scl_rise) nstate = ST_HOLD;
                ST_STEP:      nstate = ST_STEP;
                ST_HOLD:      nstate = ST_HOLD;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            rd_q   <= '0;
            data_q <= '0;
            nine_q <= 1'b0;
            pend_q <= 1'b0;
            pull_q <= 1'b0;
            stb_q  <= 1'b0;
            step_q <= 1'b0;
            up_q   <= 1'b0;
            op_q   <= '0;
            dr_q   <= '0;
            pot_q  <= 1'b0;
            kind_q <= K_BAD;
        end else begin
            stb_q  <= 1'b0;
            step_q <= 1'b0;
            if (start_det) begin
                cnt_q  <= '0;
                nine_q <= 1'b0;
                pend_q <= 1'b0;
            end else if (stop_det) begin
                cnt_q  <= '0;
                nine_q <= 1'b0;
                pend_q <= 1'b0;
                if (pend_q && (state == ST_HOLD)) begin
                    stb_q <= 1'b1;
                end
            end else if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: begin
                        sh_q  <= rx_byte;
                        cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
                        if (byte_done && (state == ST_INSTR) && (rx_kind != K_BAD)) begin
                            op_q   <= rx_byte[7:4];
                            dr_q   <= rx_byte[3:2];
                            pot_q  <= rx_byte[0];
                            kind_q <= rx_kind;
                        end
                        if (byte_done && (state == ST_WDATA)) begin
                            data_q <= rx_byte;
                        end
                    end
                    ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK: nine_q <= 1'b1;
                    ST_RDATA: cnt_q <= cnt_q + 1'b1;
                    ST_STEP: begin
                        nine_q <= 1'b1;
                        up_q   <= sda_s;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                if (in_ack) begin
                    if (!nine_q) begin
                        pull_q <= 1'b1;
                    end else begin
                        pull_q <= 1'b0;
                        nine_q <= 1'b0;
                        cnt_q  <= '0;
                        if ((state == ST_INSTR_ACK) && (kind_q == K_RD)) begin
                            rd_q   <= rd_data_i;
                            pull_q <= ~rd_data_i[BYTE_W-1];
                        end
                        if (((state == ST_INSTR_ACK) && (kind_q == K_XFR)) || (state == ST_WDATA_ACK)) begin
                            pend_q <= 1'b1;
                        end
                    end
                end else if (state == ST_RDATA) begin
                    if (cnt_q == ALL_BITS) begin
                        pull_q <= 1'b0;
                    end else begin
                        pull_q <= ~rd_q[3'd7 - cnt_q[2:0]];
                    end
                end else if ((state == ST_STEP) && nine_q) begin
                    step_q <= 1'b1;
                    nine_q <= 1'b0;
                end
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign sel_op_o   = op_q;
    assign sel_dr_o   = dr_q;
    assign sel_pot_o  = pot_q;
    assign cmd_stb_o  = stb_q;
    assign cmd_data_o = data_q;
    assign step_stb_o = step_q;
    assign step_up_o  = up_q;
endmodule

// File: rtl/pot_cmd_if_chk.sv
module pot_cmd_if_chk
    import pot_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       scl_fall,
    input fsm_e       state,
    input logic [3:0] sel_op_o,
    input logic       sda_pull_o,
    input logic       cmd_stb_o,
    input logic       step_stb_o
);
    AST_PULL_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o)); // R11

    AST_CMD_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> $past(stop_det)); // R6

    AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o); // R7

    AST_STEP_ON_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb_o |-> $past(scl_fall)); // R9

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb_o && step_stb_o)); // R10

    AST_SEL_FROM_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_op_o) |-> ($past(state) == ST_INSTR)); // R4
endmodule

bind pot_cmd_if pot_cmd_if_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .scl_fall   (scl_fall),
    .state      (state),
    .sel_op_o   (sel_op_o),
    .sda_pull_o (sda_pull_o),
    .cmd_stb_o  (cmd_stb_o),
    .step_stb_o (step_stb_o)
);

// File: tb/tb_pot_cmd_if.sv
module tb_pot_cmd_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] addr = 4'h6;
    logic       busy = 1'b0;
    logic       sda_pull;
    logic [7:0] rd_data;
    logic [3:0] sel_op;
    logic [1:0] sel_dr;
    logic       sel_pot;
    logic       cmd_stb;
    logic [7:0] cmd_data;
    logic       step_stb;
    logic       step_up;
    logic [7:0] wcr_tab [2];
    logic [7:0] dr_tab [8];
    wire        sda_bus = sda_m & ~sda_pull;

    int n_chk = 0, n_fail = 0;
    int cmd_cnt = 0, step_cnt = 0, up_cnt = 0, r11_viol = 0;
    logic [3:0] last_op;
    logic [1:0] last_dr;
    logic       last_pot;
    logic [7:0] last_data;
    logic       scl_hist = 1'b1, pull_hist = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign rd_data = (sel_op == 4'b1001) ? wcr_tab[sel_pot] : dr_tab[{sel_pot, sel_dr}];

    pot_cmd_if dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .dev_addr_i (addr),
        .nv_busy_i  (busy),
        .rd_data_i  (rd_data),
        .sel_op_o   (sel_op),
        .sel_dr_o   (sel_dr),
        .sel_pot_o  (sel_pot),
        .cmd_stb_o  (cmd_stb),
        .cmd_data_o (cmd_data),
        .step_stb_o (step_stb),
        .step_up_o  (step_up)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (cmd_stb) begin
                cmd_cnt   <= cmd_cnt + 1;
                last_op   <= sel_op;
                last_dr   <= sel_dr;
                last_pot  <= sel_pot;
                last_data <= cmd_data;
            end
            if (step_stb) begin
                step_cnt <= step_cnt + 1;
                if (step_up) up_cnt <= up_cnt + 1;
            end
            if (scl_m && scl_hist && (sda_pull !== pull_hist)) r11_viol <= r11_viol + 1;
        end
        scl_hist  <= scl_m;
        pull_hist <= sda_pull;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_id_ack(logic [7:0] id, logic [3:0] a, logic b);
        return (id[7:4] == 4'b0101) && (id[3:0] == a) && !b;
    endfunction

    // 0 bad, 1 read, 2 write, 3 transfer, 4 step
    function automatic int exp_kind(logic [7:0] ib);
        if (ib[1]) return 0;
        case (ib[7:4])
            4'b1001, 4'b1011:                   return 1;
            4'b1010, 4'b1100:                   return 2;
            4'b1101, 4'b1110, 4'b0001, 4'b1000: return 3;
            4'b0010:                            return 4;
            default:                            return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] ib);
        if (ib[7:4] == 4'b1001) return wcr_tab[ib[0]];
        return dr_tab[{ib[0], ib[3:2]}];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic s);
        sda_m = b;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(5);
        s = sda_bus;
        wait_clk(5);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_clk(6);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b0;
        wait_clk(4);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wait_clk(6);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, s);
            b[i] = s;
        end
        bit_x(!mack, s);
    endtask

    logic [3:0] valid_ops [9] = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101,
                                  4'b1110, 4'b0001, 4'b1000, 4'b0010};

    initial begin
        done = 1'b0;
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] got;
        int c0;
        void'($urandom(32'd20250611));
        for (int i = 0; i < 2; i++) wcr_tab[i] = 8'(8'h3C + i * 8'h51);
        for (int i = 0; i < 8; i++) dr_tab[i] = 8'(8'hA5 ^ (i * 37));
        wait_clk(5);
        chk("R1", "reset pull", sda_pull, 0);
        chk("R1", "reset cmd strobe", cmd_stb, 0);
        chk("R1", "reset step strobe", step_stb, 0);
        chk("R1", "reset selects", {sel_op, sel_dr, sel_pot}, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R3: busy blocks address acknowledge
        busy = 1'b1;
        do_start();
        send_byte({4'b0101, addr}, ak);
        chk("R3", "ack while busy", ak, 0);
        do_stop();
        busy = 1'b0;
        do_start();
        send_byte({4'b0101, addr}, ak);
        chk("R2", "ack after busy clears", ak, 1);
        do_stop();

        // R1: restart in the middle of the instruction byte
        c0 = cmd_cnt;
        do_start();
        send_byte({4'b0101, addr}, ak);
        for (int i = 0; i < 3; i++) bit_x(1'b1, ak);
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1110_1001, ak);
        chk("R1", "instr ack after restart", ak, 1);
        do_stop();
        chk("R1", "strobe after restarted frame", cmd_cnt, c0 + 1);
        chk("R7", "transfer op", {last_op, last_dr, last_pot}, {4'b1110, 2'b10, 1'b1});

        // R10: write aborted by repeated start after the data byte
        c0 = cmd_cnt;
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1010_0000, ak);
        send_byte(8'h5A, ak);
        chk("R6", "data ack", ak, 1);
        do_start();
        do_stop();
        chk("R10", "no strobe after restart abort", cmd_cnt, c0);
        // R10: stop after four data bits
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1100_0100, ak);
        for (int i = 0; i < 4; i++) bit_x(1'b0, ak);
        do_stop();
        chk("R10", "no strobe after early stop", cmd_cnt, c0);

        // R5: bit 1 set
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1010_0010, ak);
        chk("R5", "no ack for bit1", ak, 0);
        send_byte(8'hFF, ak);
        chk("R5", "rest ignored", ak, 0);
        do_stop();
        chk("R5", "no strobe", cmd_cnt, c0);

        // R9: step sequence
        c0 = cmd_cnt;
        begin
            int s0, u0;
            logic [4:0] pat;
            pat = 5'b11010;
            s0 = step_cnt;
            u0 = up_cnt;
            do_start();
            send_byte({4'b0101, addr}, ak);
            send_byte(8'b0010_0001, ak);
            chk("R9", "step instr ack", ak, 1);
            for (int i = 4; i >= 0; i--) bit_x(pat[i], ak);
            do_stop();
            wait_clk(4);
            chk("R9", "step count", step_cnt - s0, 5);
            chk("R9", "up count", up_cnt - u0, 3);
            chk("R9", "no command strobe", cmd_cnt, c0);
        end

        // R8: directed reads
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1011_1100, ak);
        recv_byte(got, 1'b0);
        do_stop();
        chk("R8", "read data register", got, exp_read(8'b1011_1100));
        do_start();
        send_byte({4'b0101, addr}, ak);
        send_byte(8'b1001_0001, ak);
        recv_byte(got, 1'b0);
        do_stop();
        chk("R8", "read wiper", got, exp_read(8'b1001_0001));
        chk("R8", "no strobe on read", cmd_cnt, c0);

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] id, ib, d;
            logic ida;
            int k, c1, s1, u1, ns, ups;
            id = ($urandom % 4 != 0) ? {4'b0101, addr} : 8'($urandom);
            busy = ($urandom % 10 == 0);
            if ($urandom % 4 != 0)
                ib = {valid_ops[$urandom % 9], 2'($urandom), 1'b0, 1'($urandom)};
            else
                ib = 8'($urandom);
            c1 = cmd_cnt;
            s1 = step_cnt;
            u1 = up_cnt;
            ida = exp_id_ack(id, addr, busy);
            do_start();
            send_byte(id, ak);
            chk(busy ? "R3" : "R2", "address ack", ak, ida);
            busy = 1'b0;
            if (!ida) begin
                send_byte(ib, ak);
                chk("R2", "ignored after mismatch", ak, 0);
                do_stop();
                chk("R2", "no strobe after mismatch", cmd_cnt, c1);
            end else begin
                k = exp_kind(ib);
                send_byte(ib, ak);
                chk(k == 0 ? "R5" : "R4", "instr ack", ak, (k != 0));
                if (k != 0) chk("R4", "selects", {sel_op, sel_dr, sel_pot}, {ib[7:2], ib[0]});
                case (k)
                    1: begin
                        recv_byte(got, 1'b0);
                        do_stop();
                        chk("R8", "random read", got, exp_read(ib));
                        chk("R8", "no strobe", cmd_cnt, c1);
                    end
                    2: begin
                        d = 8'($urandom);
                        send_byte(d, ak);
                        chk("R6", "data ack", ak, 1);
                        do_stop();
                        chk("R6", "write strobe", cmd_cnt, c1 + 1);
                        chk("R6", "write data", {last_op, last_data}, {ib[7:4], d});
                    end
                    3: begin
                        do_stop();
                        chk("R7", "transfer strobe", cmd_cnt, c1 + 1);
                        chk("R7", "transfer fields", {last_op, last_dr, last_pot}, {ib[7:2], ib[0]});
                    end
                    4: begin
                        ns = 1 + ($urandom % 4);
                        ups = 0;
                        for (int j = 0; j < ns; j++) begin
                            logic b;
                            b = 1'($urandom);
                            if (b) ups++;
                            bit_x(b, ak);
                        end
                        do_stop();
                        wait_clk(4);
                        chk("R9", "random steps", step_cnt - s1, ns);
                        chk("R9", "random ups", up_cnt - u1, ups);
                    end
                    default: begin
                        do_stop();
                        chk("R5", "no strobe for bad instr", cmd_cnt, c1);
                    end
                endcase
            end
        end

        chk("R11", "pull changed with SCL high", r11_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule